// File: doc/BRIEF.md
# MDIO-Addressed Board Control Register File

This block is the responder end of a two-wire management bus inside a board controller. It watches the clock (MDC) and data (MDIO) lines, finds read and write frames, and joins each frame's 5-bit device field and 5-bit register field into one 10-bit register address. Register address = device × 32 + register. Behind that address sits a small flat map. It holds identity words, a writable mode setting next to a read-only applied mode, the DIP switch levels, a system-reset trigger, power, peripheral and LED configuration words, and a board identity region at 0x300.

MDC and MDIO are sampled in the fast system clock domain through synchronizer stages. Every action of the block follows a detected MDC rising edge. The identity region is modelled as a slow store that answers one access late, so a host reads such a word twice to see the right data. A write of 1 to the reset word raises `sys_rst` for a fixed number of system clock cycles.

Top module: `mdio_board_regs`

## Requirements
- R1: After reset, `mode_set`, `power_cfg`, `peri_cfg` and `led_cfg` are 0, `sys_rst` is low and `mdio_oe` is low.
- R2: A frame is accepted only after at least 32 consecutive 1 bits followed by the start bits 0 then 1. A frame after a preamble of 31 ones is ignored. A frame after a longer preamble is accepted.
- R3: Opcode bits 1,0 select a read and 0,1 select a write, sent in that order. Opcodes 0,0 and 1,1 make the responder ignore the rest of the frame: it does not drive MDIO and changes no register until the next preamble.
- R4: The 5-bit device field and then the 5-bit register field are sent MSB first, and the register address is device×32+register. Every device value is decoded, so address 0x02E is distinct from 0x00E.
- R5: In a read frame, after the first turnaround MDC rising edge the responder drives MDIO with value 0, so the line is low when sampled after the second turnaround edge. After each of the next 16 rising edges it presents the next data bit, MSB first. It releases MDIO at the following edge. Its outputs change only right after MDC rising edges.
- R6: 0x000/0x001 return the low/high half of `product_id`. 0x002/0x003 return the low/high half of `ctrl_version`.
- R7: 0x004/0x005 are the writable low/high halves of `mode_set`. 0x006/0x007 return the low/high halves of the `mode_applied` input and ignore writes.
- R8: 0x008 returns `{4'b0, dip_b_n, dip_a_n}`: bits [7:0] are the 8-switch bank and bits [11:8] the 4-switch bank, as raw active-low levels.
- R9: 0x00B is `power_cfg`, 0x00C/0x00D are the low/high halves of `peri_cfg`, and 0x00E is `led_cfg`. All four can be read and written, and written values appear on the ports.
- R10: A write to 0x00A with data bit 0 = 1 holds `sys_rst` high for exactly RST_CYCLES (16) system clock cycles. A write with bit 0 = 0 produces no pulse. A read of 0x00A returns bit 0 = 1 only while the pulse is active, so it reads 0 after the pulse.
- R11: 0x300..0x303 hold `pcb_ver`, `soc_ver`, and `serial_no` low and high. A read there returns the word fetched by the previous read of that region (0 before any such read).
- R12: Reads of unmapped addresses return 0x0000. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen by the responder |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| dip_a_n | input | 8 | 8-switch bank, active low |
| dip_b_n | input | 4 | 4-switch bank, active low |
| mode_applied | input | 32 | Mode pins actually latched by the SoC |
| product_id | input | 32 | Product identifier |
| ctrl_version | input | 32 | Controller version |
| pcb_ver | input | 16 | PCB version, major high byte, minor low byte |
| soc_ver | input | 16 | SoC version, major high byte, minor low byte |
| serial_no | input | 32 | Board serial number |
| mode_set | output | 32 | Requested mode setting |
| power_cfg | output | 16 | Power configuration word |
| peri_cfg | output | 32 | Peripheral configuration |
| led_cfg | output | 16 | LED control word |
| sys_rst | output | 1 | System reset pulse |

## Verification
The hardest state to reach is the one-access-late identity region. Its result depends on the history of identity reads, not on the address being read. So the stimulus orders its reads carefully. It starts with a read straight after reset, which must return 0. It then repeats one address, and then switches address, so that each answer shows the previous fetch. Framing failures also cannot be seen directly: a short preamble or a bad opcode leaves no trace at the ports. The bench therefore sends LED writes wrapped in those faults, then reads the LED port and counts any cycles in which MDIO was driven.

// File: rtl/brd_pkg.sv
package brd_pkg;
   localparam int FIELD_W    = 5;
   localparam int REG_ADDR_W = 2 * FIELD_W;
   localparam int WORD_W     = 16;
   localparam int DWORD_W    = 2 * WORD_W;
   localparam int SWA_W      = 8;
   localparam int SWB_W      = 4;

   typedef logic [REG_ADDR_W-1:0] reg_addr_t;
   typedef logic [WORD_W-1:0]     word_t;

   typedef enum logic [2:0] {
      RX_HUNT, RX_START, RX_OP, RX_ADDR, RX_TA, RX_DATA, RX_REL
   } rx_state_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;

   localparam reg_addr_t RA_PROD_LO = 10'h000;
   localparam reg_addr_t RA_PROD_HI = 10'h001;
   localparam reg_addr_t RA_VER_LO  = 10'h002;
   localparam reg_addr_t RA_VER_HI  = 10'h003;
   localparam reg_addr_t RA_MODE_LO = 10'h004;
   localparam reg_addr_t RA_MODE_HI = 10'h005;
   localparam reg_addr_t RA_APPL_LO = 10'h006;
   localparam reg_addr_t RA_APPL_HI = 10'h007;
   localparam reg_addr_t RA_SWITCH  = 10'h008;
   localparam reg_addr_t RA_RESET   = 10'h00A;
   localparam reg_addr_t RA_POWER   = 10'h00B;
   localparam reg_addr_t RA_PERI_LO = 10'h00C;
   localparam reg_addr_t RA_PERI_HI = 10'h00D;
   localparam reg_addr_t RA_LED     = 10'h00E;
endpackage

// File: rtl/mdc_sync.sv
module mdc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   output logic rise,
   output logic bit_val
);
   logic mdc_s;
   logic mdc_last;

   if (STAGES < 1) begin : g_bad_stages
      $error("mdc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic mc_q, dc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mc_q <= 1'b0;
            dc_q <= 1'b1;
         end else begin
            mc_q <= mdc;
            dc_q <= mdio_i;
         end
      end
      assign mdc_s   = mc_q;
      assign bit_val = dc_q;
   end else begin : g_chain
      logic [STAGES-1:0] mc_q, dc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mc_q <= '0;
            dc_q <= '1;
         end else begin
            mc_q <= {mc_q[STAGES-2:0], mdc};
            dc_q <= {dc_q[STAGES-2:0], mdio_i};
         end
      end
      assign mdc_s   = mc_q[STAGES-1];
      assign bit_val = dc_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdc_last <= 1'b0;
      else        mdc_last <= mdc_s;
   end

   assign rise = mdc_s & ~mdc_last;

   // R5
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import brd_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rise,
   input  logic      bit_val,
   input  word_t     rd_data,
   output logic      rd_req,
   output logic      wr_stb,
   output reg_addr_t addr,
   output word_t     wr_data,
   output logic      mdio_o,
   output logic      mdio_oe
);
   localparam int PW = $clog2(PRE_LEN + 1);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] ADDR_LAST = CW'(REG_ADDR_W - 1);
   localparam logic [CW-1:0] DATA_LAST = CW'(WORD_W - 1);
   localparam logic [PW-1:0] PRE_FULL  = PW'(PRE_LEN);

   if (PRE_LEN < 2) begin : g_bad_pre
      $error("mdio_frame_rx: PRE_LEN too small");
   end

   rx_state_e      state;
   logic [PW-1:0]  pre_cnt;
   logic [CW-1:0]  bit_cnt;
   logic           op_hi;
   logic           is_rd;
   reg_addr_t      addr_sr;
   word_t          sh;

   assign rd_req  = rise && (state == RX_ADDR) && (bit_cnt == ADDR_LAST) && is_rd;
   assign wr_stb  = rise && (state == RX_DATA) && (bit_cnt == DATA_LAST) && !is_rd;
   assign addr    = (state == RX_ADDR) ? {addr_sr[REG_ADDR_W-2:0], bit_val} : addr_sr;
   assign wr_data = {sh[WORD_W-2:0], bit_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_HUNT;
         pre_cnt <= '0;
         bit_cnt <= '0;
         op_hi   <= 1'b0;
         is_rd   <= 1'b0;
         addr_sr <= '0;
         sh      <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (rise) begin
         unique case (state)
            RX_HUNT: begin
               if (bit_val) begin
                  if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
               end else begin
                  if (pre_cnt == PRE_FULL) state <= RX_START;
                  pre_cnt <= '0;
               end
            end
            RX_START: begin
               bit_cnt <= '0;
               state   <= bit_val ? RX_OP : RX_HUNT;
            end
            RX_OP: begin
               if (bit_cnt == '0) begin
                  op_hi   <= bit_val;
                  bit_cnt <= 1'b1;
               end else begin
                  bit_cnt <= '0;
                  if ({op_hi, bit_val} == OPC_READ) begin
                     is_rd <= 1'b1;
                     state <= RX_ADDR;
                  end else if ({op_hi, bit_val} == OPC_WRITE) begin
                     is_rd <= 1'b0;
                     state <= RX_ADDR;
                  end else begin
                     state <= RX_HUNT;
                  end
               end
            end
            RX_ADDR: begin
               addr_sr <= {addr_sr[REG_ADDR_W-2:0], bit_val};
               if (bit_cnt == ADDR_LAST) begin
                  bit_cnt <= '0;
                  state   <= RX_TA;
                  if (is_rd) sh <= rd_data;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            RX_TA: begin
               if (bit_cnt == '0) begin
                  bit_cnt <= 1'b1;
                  if (is_rd) begin
                     mdio_oe <= 1'b1;
                     mdio_o  <= 1'b0;
                  end
               end else begin
                  bit_cnt <= '0;
                  state   <= RX_DATA;
               end
            end
            RX_DATA: begin
               if (is_rd) begin
                  mdio_o <= sh[WORD_W-1];
                  sh     <= {sh[WORD_W-2:0], 1'b0};
               end else begin
                  sh <= {sh[WORD_W-2:0], bit_val};
               end
               if (bit_cnt == DATA_LAST) begin
                  bit_cnt <= '0;
                  pre_cnt <= '0;
                  state   <= is_rd ? RX_REL : RX_HUNT;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            RX_REL: begin
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b0;
               pre_cnt <= '0;
               state   <= RX_HUNT;
            end
            default: state <= RX_HUNT;
         endcase
      end
   end

   // R5
   ta_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   // R5
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> ($stable(mdio_o) && $stable(mdio_oe)));

   // R3
   no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !mdio_oe);

   // R3
   single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_req));
endmodule

// File: rtl/brd_regfile.sv
module brd_regfile
   import brd_pkg::*;
#(
   parameter int        RST_CYCLES = 16,
   parameter bit        STALE_ID   = 1'b1,
   parameter reg_addr_t ID_BASE    = 10'h300
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_req,
   input  logic               wr_stb,
   input  reg_addr_t          addr,
   input  word_t              wr_data,
   input  logic [SWA_W-1:0]   dip_a_n,
   input  logic [SWB_W-1:0]   dip_b_n,
   input  logic [DWORD_W-1:0] mode_applied,
   input  logic [DWORD_W-1:0] product_id,
   input  logic [DWORD_W-1:0] ctrl_version,
   input  word_t              pcb_ver,
   input  word_t              soc_ver,
   input  logic [DWORD_W-1:0] serial_no,
   output word_t              rd_data,
   output logic [DWORD_W-1:0] mode_set,
   output word_t              power_cfg,
   output logic [DWORD_W-1:0] peri_cfg,
   output word_t              led_cfg,
   output logic               sys_rst
);
   localparam int RCW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("brd_regfile: RST_CYCLES must be positive");
   end
   if (ID_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("brd_regfile: ID_BASE must be 4-word aligned");
   end

   word_t          mode_lo, mode_hi, pwr_q, peri_lo, peri_hi, led_q;
   logic [RCW-1:0] rst_cnt;
   logic           in_id;
   word_t          id_word, id_out;

   assign in_id = (addr[REG_ADDR_W-1:2] == ID_BASE[REG_ADDR_W-1:2]);

   always_comb begin
      unique case (addr[1:0])
         2'd0:    id_word = pcb_ver;
         2'd1:    id_word = soc_ver;
         2'd2:    id_word = serial_no[WORD_W-1:0];
         default: id_word = serial_no[DWORD_W-1:WORD_W];
      endcase
   end

   if (STALE_ID) begin : g_stale
      word_t stale_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                stale_q <= '0;
         else if (rd_req && in_id)  stale_q <= id_word;
      end
      assign id_out = stale_q;
   end else begin : g_direct
      assign id_out = id_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_lo <= '0;
         mode_hi <= '0;
         pwr_q   <= '0;
         peri_lo <= '0;
         peri_hi <= '0;
         led_q   <= '0;
      end else if (wr_stb) begin
         unique case (addr)
            RA_MODE_LO: mode_lo <= wr_data;
            RA_MODE_HI: mode_hi <= wr_data;
            RA_POWER:   pwr_q   <= wr_data;
            RA_PERI_LO: peri_lo <= wr_data;
            RA_PERI_HI: peri_hi <= wr_data;
            RA_LED:     led_q   <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_cnt <= '0;
      else if (wr_stb && (addr == RA_RESET) && wr_data[0])
         rst_cnt <= RCW'(RST_CYCLES);
      else if (rst_cnt != '0)
         rst_cnt <= rst_cnt - 1'b1;
   end

   assign sys_rst = (rst_cnt != '0);

   always_comb begin
      rd_data = '0;
      if (in_id) begin
         rd_data = id_out;
      end else begin
         unique case (addr)
            RA_PROD_LO: rd_data = product_id[WORD_W-1:0];
            RA_PROD_HI: rd_data = product_id[DWORD_W-1:WORD_W];
            RA_VER_LO:  rd_data = ctrl_version[WORD_W-1:0];
            RA_VER_HI:  rd_data = ctrl_version[DWORD_W-1:WORD_W];
            RA_MODE_LO: rd_data = mode_lo;
            RA_MODE_HI: rd_data = mode_hi;
            RA_APPL_LO: rd_data = mode_applied[WORD_W-1:0];
            RA_APPL_HI: rd_data = mode_applied[DWORD_W-1:WORD_W];
            RA_SWITCH:  rd_data = WORD_W'({dip_b_n, dip_a_n});
            RA_RESET:   rd_data = WORD_W'(sys_rst);
            RA_POWER:   rd_data = pwr_q;
            RA_PERI_LO: rd_data = peri_lo;
            RA_PERI_HI: rd_data = peri_hi;
            RA_LED:     rd_data = led_q;
            default:    rd_data = '0;
         endcase
      end
   end

   assign mode_set  = {mode_hi, mode_lo};
   assign power_cfg = pwr_q;
   assign peri_cfg  = {peri_hi, peri_lo};
   assign led_cfg   = led_q;

   logic [RCW:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_run <= '0;
      else if (sys_rst) hi_run <= hi_run + 1'b1;
      else              hi_run <= '0;
   end

   // R10
   rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= (RCW+1)'(RST_CYCLES));

   // R10
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(wr_stb));

   // R12
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(mode_set) && $stable(power_cfg) &&
                   $stable(peri_cfg) && $stable(led_cfg)));
endmodule

// File: rtl/mdio_board_regs.sv
module mdio_board_regs
   import brd_pkg::*;
#(
   parameter int        SYNC_STAGES = 2,
   parameter int        PRE_LEN     = 32,
   parameter int        RST_CYCLES  = 16,
   parameter bit        STALE_ID    = 1'b1,
   parameter reg_addr_t ID_BASE     = 10'h300
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mdc,
   input  logic               mdio_i,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic [SWA_W-1:0]   dip_a_n,
   input  logic [SWB_W-1:0]   dip_b_n,
   input  logic [DWORD_W-1:0] mode_applied,
   input  logic [DWORD_W-1:0] product_id,
   input  logic [DWORD_W-1:0] ctrl_version,
   input  logic [WORD_W-1:0]  pcb_ver,
   input  logic [WORD_W-1:0]  soc_ver,
   input  logic [DWORD_W-1:0] serial_no,
   output logic [DWORD_W-1:0] mode_set,
   output logic [WORD_W-1:0]  power_cfg,
   output logic [DWORD_W-1:0] peri_cfg,
   output logic [WORD_W-1:0]  led_cfg,
   output logic               sys_rst
);
   logic      rise, bit_val, rd_req, wr_stb;
   reg_addr_t addr;
   word_t     wr_data, rd_data;

   mdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .rise(rise), .bit_val(bit_val)
   );

   mdio_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .bit_val(bit_val),
      .rd_data(rd_data), .rd_req(rd_req), .wr_stb(wr_stb),
      .addr(addr), .wr_data(wr_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   brd_regfile #(
      .RST_CYCLES(RST_CYCLES), .STALE_ID(STALE_ID), .ID_BASE(ID_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_stb(wr_stb),
      .addr(addr), .wr_data(wr_data),
      .dip_a_n(dip_a_n), .dip_b_n(dip_b_n), .mode_applied(mode_applied),
      .product_id(product_id), .ctrl_version(ctrl_version),
      .pcb_ver(pcb_ver), .soc_ver(soc_ver), .serial_no(serial_no),
      .rd_data(rd_data), .mode_set(mode_set), .power_cfg(power_cfg),
      .peri_cfg(peri_cfg), .led_cfg(led_cfg), .sys_rst(sys_rst)
   );
endmodule

// File: tb/mdio_board_regs_test.sv
module mdio_board_regs_test;
   localparam logic [31:0] PROD = 32'hA5C3_1E07;
   localparam logic [31:0] VER  = 32'h0203_0110;
   localparam logic [31:0] APPL = 32'h0C0F_FEED;
   localparam logic [15:0] PCB  = 16'h0102;
   localparam logic [15:0] SOC  = 16'h0301;
   localparam logic [31:0] SN   = 32'h0012_D687;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic mdio_i = 1'b1;
   logic mdio_o, mdio_oe, sys_rst;
   logic [7:0]  dip_a_n = 8'hB6;
   logic [3:0]  dip_b_n = 4'hA;
   logic [31:0] mode_set, peri_cfg;
   logic [15:0] power_cfg, led_cfg;

   int n_cmp = 0;
   int n_bad = 0;
   int npulse = 0;
   int run_len = 0;
   int last_w = 0;
   int oe_cycles = 0;
   logic [15:0] exp_q[$];
   logic [15:0] got_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   mdio_board_regs uut (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .dip_a_n(dip_a_n), .dip_b_n(dip_b_n), .mode_applied(APPL),
      .product_id(PROD), .ctrl_version(VER), .pcb_ver(PCB), .soc_ver(SOC),
      .serial_no(SN), .mode_set(mode_set), .power_cfg(power_cfg),
      .peri_cfg(peri_cfg), .led_cfg(led_cfg), .sys_rst(sys_rst)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   always @(posedge clk) begin
      if (mdio_oe) oe_cycles++;
      if (sys_rst) run_len++;
      else if (run_len != 0) begin
         last_w = run_len;
         npulse++;
         run_len = 0;
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (got_q.size() != 0) begin
            logic [15:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g === e, t, {16'h0, g}, {16'h0, e});
         end
      end
   end

   task automatic mbit(input logic v, output logic o, output logic e);
      mdio_i = v;
      repeat (8) @(posedge clk);
      #1 mdc = 1'b1;
      repeat (8) @(posedge clk);
      #1;
      o = mdio_o;
      e = mdio_oe;
      mdc = 1'b0;
   endtask

   task automatic hdr(input int pre, input logic [1:0] op, input logic [9:0] a);
      logic o, e;
      mbit(1'b0, o, e);
      for (int i = 0; i < pre; i++) mbit(1'b1, o, e);
      mbit(1'b0, o, e);
      mbit(1'b1, o, e);
      mbit(op[1], o, e);
      mbit(op[0], o, e);
      for (int i = 9; i >= 0; i--) mbit(a[i], o, e);
   endtask

   task automatic wr(input logic [9:0] a, input logic [15:0] d,
                     input int pre = 32, input logic [1:0] op = 2'b01);
      logic o, e;
      hdr(pre, op, a);
      mbit(1'b1, o, e);
      mbit(1'b0, o, e);
      for (int i = 15; i >= 0; i--) mbit(d[i], o, e);
      mbit(1'b1, o, e);
   endtask

   task automatic rd(input logic [9:0] a, input logic [15:0] ev, input string tag);
      logic o, e;
      logic [15:0] v;
      v = '0;
      exp_q.push_back(ev);
      tag_q.push_back(tag);
      hdr(32, 2'b10, a);
      mbit(1'b1, o, e);
      mbit(1'b1, o, e);
      chk(e === 1'b1 && o === 1'b0, "R5 turnaround low", {30'h0, o, e}, 32'h1);
      for (int i = 0; i < 16; i++) begin
         mbit(1'b1, o, e);
         v = {v[14:0], o};
      end
      got_q.push_back(v);
      mbit(1'b1, o, e);
      chk(e === 1'b0, "R5 release", {31'h0, e}, 32'h0);
      mbit(1'b1, o, e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int np, oc;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      // R1 reset state
      chk(mode_set === 32'h0, "R1 mode_set", mode_set, 32'h0);
      chk(power_cfg === 16'h0 && led_cfg === 16'h0, "R1 power/led", {power_cfg, led_cfg}, 32'h0);
      chk(peri_cfg === 32'h0, "R1 peri_cfg", peri_cfg, 32'h0);
      chk(sys_rst === 1'b0 && mdio_oe === 1'b0, "R1 rst/oe", {30'h0, sys_rst, mdio_oe}, 32'h0);

      // R6 identity words
      rd(10'h000, PROD[15:0], "R6 product lo");
      rd(10'h001, PROD[31:16], "R6 product hi");
      rd(10'h002, VER[15:0], "R6 version lo");
      rd(10'h003, VER[31:16], "R6 version hi");

      // R7 mode set / applied
      wr(10'h004, 16'hBEEF);
      wr(10'h005, 16'h1357);
      chk(mode_set === 32'h1357_BEEF, "R7 mode_set port", mode_set, 32'h1357_BEEF);
      rd(10'h004, 16'hBEEF, "R7 mode lo readback");
      rd(10'h005, 16'h1357, "R7 mode hi readback");
      rd(10'h006, APPL[15:0], "R7 applied lo");
      rd(10'h007, APPL[31:16], "R7 applied hi");
      wr(10'h006, 16'h0000);
      rd(10'h006, APPL[15:0], "R7 R12 applied write ignored");
      chk(mode_set === 32'h1357_BEEF, "R12 mode_set untouched", mode_set, 32'h1357_BEEF);

      // R8 switches
      rd(10'h008, 16'h0AB6, "R8 dip switches");

      // R9 config words
      wr(10'h00B, 16'h00C3);
      wr(10'h00C, 16'h1111);
      wr(10'h00D, 16'h2222);
      wr(10'h00E, 16'h005A);
      chk(power_cfg === 16'h00C3, "R9 power port", {16'h0, power_cfg}, 32'h00C3);
      chk(peri_cfg === 32'h2222_1111, "R9 peri port", peri_cfg, 32'h2222_1111);
      chk(led_cfg === 16'h005A, "R9 led port", {16'h0, led_cfg}, 32'h005A);
      rd(10'h00B, 16'h00C3, "R9 power readback");
      rd(10'h00D, 16'h2222, "R9 peri hi readback");

      // R10 reset pulse
      np = npulse;
      wr(10'h00A, 16'h0000);
      chk(npulse == np, "R10 no pulse on 0", npulse, np);
      wr(10'h00A, 16'h0001);
      repeat (4) @(posedge clk);
      chk(npulse == np + 1, "R10 pulse count", npulse, np + 1);
      chk(last_w == 16, "R10 pulse width", last_w, 16);
      rd(10'h00A, 16'h0000, "R10 reset reads 0 after pulse");

      // R11 stale identity region (R4: device 24)
      rd(10'h301, 16'h0000, "R11 first read stale zero");
      rd(10'h301, SOC, "R11 soc second read");
      rd(10'h300, SOC, "R11 pcb first read stale");
      rd(10'h300, PCB, "R11 pcb second read");
      rd(10'h302, PCB, "R11 sn lo first read stale");
      rd(10'h302, SN[15:0], "R11 sn lo");
      rd(10'h303, SN[15:0], "R11 sn hi first read stale");
      rd(10'h303, SN[31:16], "R11 sn hi");

      // R4 device field decoded
      wr(10'h02E, 16'hFFFF);
      chk(led_cfg === 16'h005A, "R4 dev1 write misses led", {16'h0, led_cfg}, 32'h005A);
      rd(10'h02E, 16'h0000, "R4 R12 dev1 reg14 unmapped");

      // R12 unmapped / read-only
      rd(10'h009, 16'h0000, "R12 unmapped 0x009");
      rd(10'h3FF, 16'h0000, "R12 unmapped 0x3FF");
      wr(10'h000, 16'hFFFF);
      rd(10'h000, PROD[15:0], "R12 read-only write ignored");

      // R2 preamble length
      wr(10'h00E, 16'h00FF, 31);
      chk(led_cfg === 16'h005A, "R2 short preamble ignored", {16'h0, led_cfg}, 32'h005A);
      wr(10'h00E, 16'h0033, 33);
      chk(led_cfg === 16'h0033, "R2 long preamble accepted", {16'h0, led_cfg}, 32'h0033);

      // R3 bad opcodes
      oc = oe_cycles;
      wr(10'h00E, 16'h00AA, 32, 2'b11);
      wr(10'h00E, 16'h0055, 32, 2'b00);
      chk(led_cfg === 16'h0033, "R3 bad opcode no write", {16'h0, led_cfg}, 32'h0033);
      chk(oe_cycles == oc, "R3 bad opcode no drive", oe_cycles, oc);
      rd(10'h00E, 16'h0033, "R3 recovery read");

      repeat (10) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule